// File: doc/BRIEF.md
# CAN Transmit Buffer Abort Controller

This block keeps the status and control bits of three CAN transmit message buffers. For each buffer it holds an empty flag, an abort request bit, an abort acknowledge flag and an interrupt enable. Software uses two register images to schedule buffers, request aborts and enable interrupts. A flag image carries the empty and acknowledge flags. A control image carries the abort requests and the enables. A transmit engine outside the block reports per-buffer pulses when a frame starts, finishes well, or fails through lost arbitration or an error. The block decides whether an abort is granted, updates the flags and drives one transmit interrupt.

Each buffer is tracked by its own state machine with three states. SLOT_EMPTY: not scheduled. SLOT_QUEUED: scheduled and waiting for the engine. SLOT_ACTIVE: the engine is sending it. The transitions are as follows. SLOT_EMPTY goes to SLOT_QUEUED when software schedules the buffer. SLOT_QUEUED goes to SLOT_EMPTY when an abort is pending (the abort is granted), and otherwise to SLOT_ACTIVE on a start pulse. SLOT_ACTIVE goes to SLOT_EMPTY on success. On a failure, SLOT_ACTIVE goes to SLOT_EMPTY if an abort is pending (the abort is granted) and back to SLOT_QUEUED if none is pending, so the frame can be retried. Every other case holds the state.

The write port has separate strobes and data buses for the two images, so both images can be written in the same cycle. Every register updates on the clock edge of the write, and its new value is visible from the next cycle on.

Top module: `can_txbuf_abort_ctl`

## Requirements
- R1: After reset, the flag image reads 0x07 (all buffers empty, all acknowledges 0) and the control image reads 0x00.
- R2: Control image layout: abort request of buffer i at bit 4+i and interrupt enable of buffer i at bit i. Flag image layout: empty flag of buffer i at bit i and acknowledge of buffer i at bit 4+i. Bits 7 and 3 of both images read 0. A control write loads all enables from bits 2:0.
- R3: A flag write with bit i at 1 schedules an empty buffer i. Its empty flag and its acknowledge both read 0 from the next cycle on. Writing 0, or writing to an already scheduled buffer, has no effect.
- R4: A control write with bit 4+i at 1 sets the abort request of buffer i only while that buffer is scheduled. Writing 0 never clears the request. A request written in the same cycle as the write that schedules the buffer is ignored.
- R5: A queued buffer with a pending abort request is withdrawn one cycle later: its empty flag becomes 1, its acknowledge becomes 1 and its request becomes 0.
- R6: For an active buffer with a pending abort, a success sets the empty flag with acknowledge 0. A failure sets the empty flag with acknowledge 1.
- R7: A failure with no pending abort returns the buffer to the queued state, still scheduled and ready again.
- R8: Output tx_ready bit i is 1 only when buffer i is queued with no abort pending. A start pulse for a buffer that is not ready is ignored.
- R9: tx_irq is 1 exactly when some buffer has both its empty flag and its interrupt enable at 1.
- R10: While srst is 1, both images are held at their reset values and all writes and engine pulses are ignored.
- R11: A buffer's abort request is never 1 while its empty flag is 1. A request is cleared in the same cycle its empty flag becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| srst | input | 1 | Soft reset hold, active high |
| flag_wr | input | 1 | Write strobe for the flag image |
| flag_wdata | input | 8 | Flag write data (1 in bit i schedules buffer i) |
| ctrl_wr | input | 1 | Write strobe for the control image |
| ctrl_wdata | input | 8 | Control write data |
| eng_start | input | 3 | Per-buffer frame start pulse |
| eng_ok | input | 3 | Per-buffer successful completion pulse |
| eng_fail | input | 3 | Per-buffer failed attempt pulse (lost arbitration or error) |
| flag_rdata | output | 8 | Flag image readback |
| ctrl_rdata | output | 8 | Control image readback |
| tx_ready | output | 3 | Buffers the engine may start |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
On every cycle, the assertions check the invariants that link the two images. These are: no abort request on an empty buffer, no acknowledge on a scheduled buffer, no ready bit on an empty or aborting buffer, the interrupt equation, the zero bits, and the soft reset hold. Some behaviours can only be shown by the bench's scenarios compared against its reference model. These are the grant timing before and after a start, success overriding a pending abort, retry after a failure, a request ignored when it coincides with scheduling, and writes of 0 having no effect.

// File: rtl/txabort_pkg.sv
package txabort_pkg;
    localparam int REG_W   = 8;
    localparam int HI_LSB  = 4;

    typedef enum logic [1:0] {
        SLOT_EMPTY  = 2'd0,
        SLOT_QUEUED = 2'd1,
        SLOT_ACTIVE = 2'd2
    } slot_state_t;
endpackage

// File: rtl/txbuf_slot_fsm.sv
module txbuf_slot_fsm
    import txabort_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst_i,
    input  logic sched_i,
    input  logic abort_set_i,
    input  logic start_i,
    input  logic done_ok_i,
    input  logic fail_i,
    output logic empty_o,
    output logic ack_o,
    output logic abort_o,
    output logic ready_o
);
    slot_state_t state_q, state_d;
    logic        ack_q, ack_d;
    logic        abort_q, abort_d;
    logic        grant;

    // next-state and flag update logic
    always_comb begin
        state_d = state_q;
        grant   = 1'b0;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (sched_i) state_d = SLOT_QUEUED;
            end
            SLOT_QUEUED: begin
                if (abort_q) begin
                    state_d = SLOT_EMPTY;
                    grant   = 1'b1;
                end else if (start_i) begin
                    state_d = SLOT_ACTIVE;
                end
            end
            SLOT_ACTIVE: begin
                if (done_ok_i) begin
                    state_d = SLOT_EMPTY;
                end else if (fail_i) begin
                    if (abort_q) begin
                        state_d = SLOT_EMPTY;
                        grant   = 1'b1;
                    end else begin
                        state_d = SLOT_QUEUED;
                    end
                end
            end
            default: state_d = SLOT_EMPTY;
        endcase

        if (grant)
            ack_d = 1'b1;
        else if (state_q == SLOT_EMPTY && state_d == SLOT_QUEUED)
            ack_d = 1'b0;
        else
            ack_d = ack_q;

        if (state_d == SLOT_EMPTY)
            abort_d = 1'b0;
        else if (abort_set_i && state_q != SLOT_EMPTY)
            abort_d = 1'b1;
        else
            abort_d = abort_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            ack_q   <= 1'b0;
            abort_q <= 1'b0;
        end else if (srst_i) begin
            state_q <= SLOT_EMPTY;
            ack_q   <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_q   <= ack_d;
            abort_q <= abort_d;
        end
    end

    // outputs
    always_comb begin
        empty_o = (state_q == SLOT_EMPTY);
        ready_o = (state_q == SLOT_QUEUED) && !abort_q;
        ack_o   = ack_q;
        abort_o = abort_q;
    end
endmodule

// File: rtl/txirq_merge.sv
module txirq_merge #(
    parameter int NBUF = 3
) (
    input  logic [NBUF-1:0] empty_i,
    input  logic [NBUF-1:0] enable_i,
    output logic            irq_o
);
    logic [NBUF-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NBUF; g++) begin : g_hit
            assign hit[g] = empty_i[g] & enable_i[g];
        end
    endgenerate

    assign irq_o = |hit;
endmodule

// File: rtl/can_txbuf_abort_ctl.sv
module can_txbuf_abort_ctl
    import txabort_pkg::*;
#(
    parameter int NBUF = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  srst,
    input  logic                  flag_wr,
    input  logic [REG_W-1:0]      flag_wdata,
    input  logic                  ctrl_wr,
    input  logic [REG_W-1:0]      ctrl_wdata,
    input  logic [NBUF-1:0]       eng_start,
    input  logic [NBUF-1:0]       eng_ok,
    input  logic [NBUF-1:0]       eng_fail,
    output logic [REG_W-1:0]      flag_rdata,
    output logic [REG_W-1:0]      ctrl_rdata,
    output logic [NBUF-1:0]       tx_ready,
    output logic                  tx_irq
);
    localparam int USED_LO = NBUF;
    localparam int USED_HI = HI_LSB + NBUF;

    logic [NBUF-1:0] empty, ack, abort_req, ie_q;
    logic            unused_wbits;

    assign unused_wbits = ^{flag_wdata[REG_W-1:USED_LO], ctrl_wdata[REG_W-1:USED_HI],
                            ctrl_wdata[HI_LSB-1:USED_LO]};

    genvar g;
    generate
        for (g = 0; g < NBUF; g++) begin : g_slot
            txbuf_slot_fsm u_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .srst_i      (srst),
                .sched_i     (flag_wr & flag_wdata[g]),
                .abort_set_i (ctrl_wr & ctrl_wdata[HI_LSB + g]),
                .start_i     (eng_start[g]),
                .done_ok_i   (eng_ok[g]),
                .fail_i      (eng_fail[g]),
                .empty_o     (empty[g]),
                .ack_o       (ack[g]),
                .abort_o     (abort_req[g]),
                .ready_o     (tx_ready[g])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ie_q <= '0;
        else if (srst)    ie_q <= '0;
        else if (ctrl_wr) ie_q <= ctrl_wdata[NBUF-1:0];
    end

    txirq_merge #(.NBUF(NBUF)) u_irq (
        .empty_i  (empty),
        .enable_i (ie_q),
        .irq_o    (tx_irq)
    );

    always_comb begin
        flag_rdata = '0;
        ctrl_rdata = '0;
        flag_rdata[NBUF-1:0]        = empty;
        flag_rdata[HI_LSB +: NBUF]  = ack;
        ctrl_rdata[NBUF-1:0]        = ie_q;
        ctrl_rdata[HI_LSB +: NBUF]  = abort_req;
    end
endmodule

// File: rtl/can_txbuf_abort_sva.sv
module can_txbuf_abort_sva #(
    parameter int NBUF = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            srst,
    input logic [7:0]      flag_rdata,
    input logic [7:0]      ctrl_rdata,
    input logic [NBUF-1:0] tx_ready,
    input logic            tx_irq
);
    logic [NBUF-1:0] e_v, a_v, k_v, ie_v;
    assign e_v  = flag_rdata[NBUF-1:0];
    assign k_v  = flag_rdata[4 +: NBUF];
    assign a_v  = ctrl_rdata[4 +: NBUF];
    assign ie_v = ctrl_rdata[NBUF-1:0];

    assert_no_abort_on_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (e_v & a_v) == '0);

    assert_ack_only_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (k_v & ~e_v) == '0);

    assert_ready_only_queued_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready & (e_v | a_v)) == '0);

    assert_irq_equation_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq == |(e_v & ie_v));

    assert_soft_reset_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (flag_rdata == 8'h07 && ctrl_rdata == 8'h00));

    assert_unused_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_rdata[7] && !flag_rdata[3] && !ctrl_rdata[7] && !ctrl_rdata[3]);
endmodule

bind can_txbuf_abort_ctl can_txbuf_abort_sva #(.NBUF(NBUF)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .srst       (srst),
    .flag_rdata (flag_rdata),
    .ctrl_rdata (ctrl_rdata),
    .tx_ready   (tx_ready),
    .tx_irq     (tx_irq)
);

// File: tb/tb_can_txbuf_abort_ctl.sv
`timescale 1ns/1ps
module tb_can_txbuf_abort_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       srst = 1'b0;
    logic       flag_wr = 1'b0;
    logic [7:0] flag_wdata = '0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [2:0] eng_start = '0, eng_ok = '0, eng_fail = '0;
    logic [7:0] flag_rdata, ctrl_rdata;
    logic [2:0] tx_ready;
    logic       tx_irq;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    n_cycles = 0;
    string cur_req  = "R1";

    always #4 clk = ~clk;

    can_txbuf_abort_ctl dut (
        .clk(clk), .rst_n(rst_n), .srst(srst),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .eng_start(eng_start), .eng_ok(eng_ok), .eng_fail(eng_fail),
        .flag_rdata(flag_rdata), .ctrl_rdata(ctrl_rdata),
        .tx_ready(tx_ready), .tx_irq(tx_irq)
    );

    // reference model: 0 idle, 1 waiting, 2 sending
    int m_st [3];
    int m_ack[3];
    int m_ab [3];
    int m_ie [3];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || srst) begin
            for (int i = 0; i < 3; i++) begin
                m_st[i] = 0; m_ack[i] = 0; m_ab[i] = 0; m_ie[i] = 0;
            end
        end else begin
            for (int i = 0; i < 3; i++) begin
                int was;
                was = m_st[i];
                if (was == 0 && flag_wr && flag_wdata[i]) begin
                    m_st[i] = 1; m_ack[i] = 0;
                end else if (was == 1) begin
                    if (m_ab[i] != 0) begin m_st[i] = 0; m_ack[i] = 1; end
                    else if (eng_start[i]) m_st[i] = 2;
                end else if (was == 2) begin
                    if (eng_ok[i]) m_st[i] = 0;
                    else if (eng_fail[i]) begin
                        if (m_ab[i] != 0) begin m_st[i] = 0; m_ack[i] = 1; end
                        else m_st[i] = 1;
                    end
                end
                if (m_st[i] == 0) m_ab[i] = 0;
                else if (was != 0 && ctrl_wr && ctrl_wdata[4+i]) m_ab[i] = 1;
                if (ctrl_wr) m_ie[i] = ctrl_wdata[i] ? 1 : 0;
            end
        end
    end

    task automatic check8(string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] ef, ec, er, ei;
            ef = '0; ec = '0; er = '0; ei = '0;
            for (int i = 0; i < 3; i++) begin
                ef[i]   = (m_st[i] == 0);
                ef[4+i] = (m_ack[i] != 0);
                ec[i]   = (m_ie[i] != 0);
                ec[4+i] = (m_ab[i] != 0);
                er[i]   = (m_st[i] == 1) && (m_ab[i] == 0);
                if (m_st[i] == 0 && m_ie[i] != 0) ei[0] = 1'b1;
            end
            check8("flag image", flag_rdata, ef);
            check8("control image", ctrl_rdata, ec);
            check8("tx_ready", {5'd0, tx_ready}, er);
            check8("tx_irq", {7'd0, tx_irq}, ei);
        end
    end

    // drive one cycle of stimulus, then return to idle inputs
    task automatic drive(input logic fw, input logic [7:0] fd, input logic cw,
                         input logic [7:0] cd, input logic [2:0] st,
                         input logic [2:0] ok, input logic [2:0] fl);
        @(negedge clk);
        flag_wr = fw; flag_wdata = fd; ctrl_wr = cw; ctrl_wdata = cd;
        eng_start = st; eng_ok = ok; eng_fail = fl;
        @(negedge clk);
        flag_wr = 0; flag_wdata = '0; ctrl_wr = 0; ctrl_wdata = '0;
        eng_start = '0; eng_ok = '0; eng_fail = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        n_cycles++;
        if (n_cycles > 5000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", n_cycles);
            finish_run();
        end
    end

    initial begin
        cur_req = "R1";
        idle(2);
        rst_n = 1'b1;
        idle(3);

        cur_req = "R2";   // enables load, aborts on empty buffers ignored
        drive(0, 8'h00, 1, 8'hFF, 3'b000, 3'b000, 3'b000);
        idle(2);

        cur_req = "R9";
        drive(0, 8'h00, 1, 8'h04, 3'b000, 3'b000, 3'b000);
        idle(1);

        cur_req = "R3";   // schedule buffers 0 and 1, zero bits leave buffer 2 alone
        drive(1, 8'hF3, 0, 8'h00, 3'b000, 3'b000, 3'b000);
        drive(1, 8'h03, 0, 8'h00, 3'b000, 3'b000, 3'b000);
        idle(2);

        cur_req = "R8";   // start buffer 1, start on empty buffer 2 ignored
        drive(0, 8'h00, 0, 8'h00, 3'b110, 3'b000, 3'b000);
        idle(2);

        cur_req = "R5";   // abort queued buffer 0
        drive(0, 8'h00, 1, 8'h14, 3'b000, 3'b000, 3'b000);
        idle(3);

        cur_req = "R6";   // abort on active buffer 1, then success
        drive(0, 8'h00, 1, 8'h24, 3'b000, 3'b000, 3'b000);
        idle(2);
        drive(0, 8'h00, 0, 8'h00, 3'b000, 3'b010, 3'b000);
        idle(1);
        drive(1, 8'h02, 0, 8'h00, 3'b000, 3'b000, 3'b000);
        drive(0, 8'h00, 0, 8'h00, 3'b010, 3'b000, 3'b000);
        drive(0, 8'h00, 1, 8'h24, 3'b000, 3'b000, 3'b000);
        drive(0, 8'h00, 0, 8'h00, 3'b000, 3'b000, 3'b010);
        idle(2);

        cur_req = "R7";   // failure without abort retries
        drive(1, 8'h04, 0, 8'h00, 3'b000, 3'b000, 3'b000);
        drive(0, 8'h00, 0, 8'h00, 3'b100, 3'b000, 3'b000);
        drive(0, 8'h00, 0, 8'h00, 3'b000, 3'b000, 3'b100);
        idle(2);
        drive(0, 8'h00, 0, 8'h00, 3'b100, 3'b000, 3'b000);
        drive(0, 8'h00, 0, 8'h00, 3'b000, 3'b100, 3'b000);
        idle(1);

        cur_req = "R4";   // same-cycle schedule and abort: abort ignored
        drive(1, 8'h01, 1, 8'h13, 3'b000, 3'b000, 3'b000);
        idle(2);
        drive(0, 8'h00, 0, 8'h00, 3'b001, 3'b000, 3'b000);
        drive(0, 8'h00, 1, 8'h13, 3'b000, 3'b000, 3'b000);
        drive(0, 8'h00, 1, 8'h03, 3'b000, 3'b000, 3'b000);
        idle(2);

        cur_req = "R11";  // success clears the pending request with the flag
        drive(0, 8'h00, 0, 8'h00, 3'b000, 3'b001, 3'b000);
        idle(2);

        cur_req = "R10";  // soft reset hold ignores writes and engine pulses
        drive(1, 8'h07, 0, 8'h00, 3'b000, 3'b000, 3'b000);
        @(negedge clk);
        srst = 1'b1;
        drive(1, 8'h07, 1, 8'h77, 3'b111, 3'b000, 3'b000);
        idle(2);
        srst = 1'b0;
        idle(3);

        cur_req = "R1";
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(2);
        finish_run();
    end
endmodule